// File: doc/BRIEF.md
# Byte-Lane Banked DRAM Expansion Controller

The controller sits between a 16-bit host bus and a 256 KiB memory expansion. The memory is built from 64K-deep DRAM devices in two banks, and each bank has a lower and an upper byte lane. The host presents a 17-bit word address, a write flag, two byte enables and write data. The block turns each access into a multiplexed DRAM cycle. An 8-bit row goes out with a single row strobe that every device shares. An 8-bit column follows, and the column strobes that fire decide which bank and which lanes take part.

The sequencer steps through fixed phases: row setup, row strobe, column setup, column strobe, release and precharge. A parameter sets the length of each phase in clock cycles. An internal timer asks for a refresh at a set interval. The refresh pulls all four column strobes low before the row strobe. A pending refresh takes the next idle slot ahead of a waiting host request. It never cuts into an access that has already started.

The host holds the request steady until `req_ack` pulses and may then change it. An access is accepted only when the sequencer is idle. Read data is valid on `req_rdata` from the acknowledge cycle until the next read completes.

Top module: `bytelane_dram_ctl`

## Requirements
- R1: Address bits 15:8 appear on `dram_addr` when the row strobe falls, and bits 7:0 appear when the column strobes fall. The value is stable across each falling edge.
- R2: Address bit 16 selects the bank. Column strobe index 0 is bank 0 lower lane, 1 is bank 0 upper lane, 2 is bank 1 lower lane and 3 is bank 1 upper lane. Strobes of the two banks are never low together during an access.
- R3: With both byte enables set, the lower and upper column strobes of the selected bank fall together.
- R4: With one byte enable set (bit 0 is the lower lane, data bits 7:0; bit 1 is the upper lane, data bits 15:8), only that lane's column strobe of the selected bank falls.
- R5: On a write, `dram_we_n` is low and `dram_dq_oe` is high, with the write data on the enabled lanes, at least one cycle before the column strobes fall. Write enable is only ever low while the row strobe is low.
- R6: On a read, data on `dram_dq_in` is captured in the last column-strobe cycle and returned on `req_rdata`. Lanes that are not enabled read as zero.
- R7: `req_ack` is high for exactly one cycle per request, and no strobe is low during that cycle. A request with both byte enables clear is acknowledged without any strobe falling.
- R8: A refresh occurs once every `REFRESH_INTERVAL` cycles. In a refresh, all four column strobes go low at least one cycle before the row strobe falls.
- R9: A refresh never starts while an access holds the row strobe low. Under back-to-back requests, refreshes still keep their rate.
- R10: During reset all strobes and write enable are high, the data bus is not driven, `req_ack` is low and `req_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address: bank, row, column |
| req_be | input | 2 | Byte enables, bit 0 lower lane |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Shared row strobe, active low |
| dram_cas_n | output | 4 | Column strobes per bank and lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 16 | Write data to devices |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | 16 | Read data from devices |

## Verification
Directed accesses cover both banks at the extreme addresses, every byte-enable pattern and a request with no byte enable. These separate bank decoding from lane decoding, and they show whether a disabled lane leaks into the read data. Random traffic is drawn from a small address pool so that reads hit earlier writes. A wrong row, column or lane mapping then shows up as a data mismatch in a bench memory model. An idle window shows the refresh rate, and a saturated stream of requests shows that refresh is neither starved nor allowed to interrupt an access.

// File: rtl/bldram_pkg.sv
package bldram_pkg;
  localparam int HALF_W = 8;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int BANKS  = 2;
  localparam int BANK_W = $clog2(BANKS);
  localparam int CAS_W  = BANKS * LANES;
  localparam int DATA_W = LANES * LANE_W;
  localparam int ADDR_W = BANK_W + 2 * HALF_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ROW_SU, ST_RAS, ST_COL_SU, ST_CAS,
    ST_REL, ST_PRE, ST_NULL, ST_RF_CAS, ST_RF_RAS
  } seq_state_e;

  typedef struct packed {
    logic              we;
    logic [LANES-1:0]  be;
    logic [BANK_W-1:0] bank;
    logic [HALF_W-1:0] row;
    logic [HALF_W-1:0] col;
    logic [DATA_W-1:0] wdata;
  } dram_req_t;
endpackage

// File: rtl/bldram_refresh.sv
module bldram_refresh #(
  parameter int INTERVAL = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rf_start,
  output logic rf_pending
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] tmr_q, tmr_d;
  logic          tick;
  logic          pend_d;

  always_comb begin
    tick   = (tmr_q == CW'(INTERVAL - 1));
    tmr_d  = tick ? '0 : tmr_q + 1'b1;
    pend_d = tick | (rf_pending & ~rf_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q      <= '0;
      rf_pending <= 1'b0;
    end else begin
      tmr_q      <= tmr_d;
      rf_pending <= pend_d;
    end
  end
endmodule

// File: rtl/bldram_seq.sv
module bldram_seq
  import bldram_pkg::*;
#(
  parameter int T_ROW_SU = 1,
  parameter int T_RAS    = 1,
  parameter int T_COL_SU = 1,
  parameter int T_CAS    = 2,
  parameter int T_REL    = 1,
  parameter int T_PRE    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       be_none,
  input  logic       rf_pending,
  output seq_state_e state,
  output logic       accept,
  output logic       rf_start,
  output logic       capture,
  output logic       ack
);
  function automatic int tmax();
    int m = T_ROW_SU;
    if (T_RAS > m)    m = T_RAS;
    if (T_COL_SU > m) m = T_COL_SU;
    if (T_CAS > m)    m = T_CAS;
    if (T_REL > m)    m = T_REL;
    if (T_PRE > m)    m = T_PRE;
    return m;
  endfunction

  localparam int T_MAX = tmax();
  localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;

  function automatic logic [CNT_W-1:0] dur(seq_state_e s);
    case (s)
      ST_ROW_SU: return CNT_W'(T_ROW_SU - 1);
      ST_RAS:    return CNT_W'(T_RAS - 1);
      ST_COL_SU: return CNT_W'(T_COL_SU - 1);
      ST_CAS:    return CNT_W'(T_CAS - 1);
      ST_REL:    return CNT_W'(T_REL - 1);
      ST_PRE:    return CNT_W'(T_PRE - 1);
      ST_RF_CAS: return CNT_W'(T_CAS - 1);
      ST_RF_RAS: return CNT_W'(T_RAS - 1);
      default:   return '0;
    endcase
  endfunction

  seq_state_e       state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rf_act_q, rf_act_d;
  logic             last;
  logic             cnt_en;

  always_comb begin
    last     = (cnt_q == '0);
    state_d  = state;
    accept   = 1'b0;
    rf_start = 1'b0;
    case (state)
      ST_IDLE: begin
        if (rf_pending) begin
          rf_start = 1'b1;
          state_d  = ST_RF_CAS;
        end else if (req_valid) begin
          accept  = 1'b1;
          state_d = be_none ? ST_NULL : ST_ROW_SU;
        end
      end
      ST_ROW_SU: if (last) state_d = ST_RAS;
      ST_RAS:    if (last) state_d = ST_COL_SU;
      ST_COL_SU: if (last) state_d = ST_CAS;
      ST_CAS:    if (last) state_d = ST_REL;
      ST_REL:    if (last) state_d = ST_PRE;
      ST_PRE:    if (last) state_d = ST_IDLE;
      ST_NULL:   state_d = ST_IDLE;
      ST_RF_CAS: if (last) state_d = ST_RF_RAS;
      ST_RF_RAS: if (last) state_d = ST_PRE;
      default:   state_d = ST_IDLE;
    endcase

    cnt_en = (state_d != state) || (cnt_q != '0);
    cnt_d  = (state_d != state) ? dur(state_d) : cnt_q - 1'b1;

    rf_act_d = rf_start ? 1'b1 : (state == ST_IDLE) ? 1'b0 : rf_act_q;

    capture = (state == ST_CAS) && last;
    ack     = ((state == ST_PRE) && last && !rf_act_q) || (state == ST_NULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt_q    <= '0;
      rf_act_q <= 1'b0;
    end else begin
      state    <= state_d;
      rf_act_q <= rf_act_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bldram_strobe_dec.sv
module bldram_strobe_dec
  import bldram_pkg::*;
(
  input  seq_state_e        state,
  input  dram_req_t         req,
  output logic [HALF_W-1:0] dram_addr,
  output logic              dram_ras_n,
  output logic [CAS_W-1:0]  dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe
);
  logic [CAS_W-1:0] sel;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign sel[b*LANES+l] = req.be[l] && (req.bank == BANK_W'(b));
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_wlane
    assign dram_dq_out[l*LANE_W +: LANE_W] = req.be[l] ? req.wdata[l*LANE_W +: LANE_W] : '0;
  end

  logic col_phase;
  logic wr_phase;

  always_comb begin
    col_phase  = (state == ST_COL_SU) || (state == ST_CAS) || (state == ST_REL);
    dram_addr  = col_phase ? req.col : req.row;
    dram_ras_n = !((state == ST_RAS) || (state == ST_COL_SU) ||
                   (state == ST_CAS) || (state == ST_RF_RAS));
    case (state)
      ST_CAS:               dram_cas_n = ~sel;
      ST_RF_CAS, ST_RF_RAS: dram_cas_n = '0;
      default:              dram_cas_n = '1;
    endcase
    wr_phase   = req.we && ((state == ST_COL_SU) || (state == ST_CAS));
    dram_we_n  = !wr_phase;
    dram_dq_oe = wr_phase;
  end
endmodule

// File: rtl/bytelane_dram_ctl.sv
module bytelane_dram_ctl
  import bldram_pkg::*;
#(
  parameter int T_ROW_SU         = 1,
  parameter int T_RAS            = 1,
  parameter int T_COL_SU         = 1,
  parameter int T_CAS            = 2,
  parameter int T_REL            = 1,
  parameter int T_PRE            = 2,
  parameter int REFRESH_INTERVAL = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] req_rdata,
  output logic [HALF_W-1:0] dram_addr,
  output logic              dram_ras_n,
  output logic [CAS_W-1:0]  dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seq_state_e        state;
  logic              accept, rf_start, rf_pending, capture;
  dram_req_t         req_q, req_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    req_d.we    = req_we;
    req_d.be    = req_be;
    req_d.bank  = req_addr[ADDR_W-1 -: BANK_W];
    req_d.row   = req_addr[2*HALF_W-1 -: HALF_W];
    req_d.col   = req_addr[HALF_W-1:0];
    req_d.wdata = req_wdata;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rlane
    assign rdata_d[l*LANE_W +: LANE_W] = req_q.be[l] ? dram_dq_in[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q     <= '0;
      req_rdata <= '0;
    end else begin
      if (accept)  req_q     <= req_d;
      if (capture) req_rdata <= rdata_d;
    end
  end

  bldram_refresh #(.INTERVAL(REFRESH_INTERVAL)) u_refresh (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rf_start   (rf_start),
    .rf_pending (rf_pending)
  );

  bldram_seq #(
    .T_ROW_SU (T_ROW_SU), .T_RAS (T_RAS), .T_COL_SU (T_COL_SU),
    .T_CAS    (T_CAS),    .T_REL (T_REL), .T_PRE    (T_PRE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .be_none    (req_be == '0),
    .rf_pending (rf_pending),
    .state      (state),
    .accept     (accept),
    .rf_start   (rf_start),
    .capture    (capture),
    .ack        (req_ack)
  );

  bldram_strobe_dec u_dec (
    .state       (state),
    .req         (req_q),
    .dram_addr   (dram_addr),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_dq_out (dram_dq_out),
    .dram_dq_oe  (dram_dq_oe)
  );
endmodule

// File: rtl/bldram_ctl_chk.sv
module bldram_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ack,
  input logic [7:0] dram_addr,
  input logic       dram_ras_n,
  input logic [3:0] dram_cas_n,
  input logic       dram_we_n,
  input logic       dram_dq_oe
);
  p_cas_first_refresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n && dram_cas_n != 4'hF) |-> (dram_cas_n == 4'h0));

  p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && dram_cas_n != 4'h0) |->
      !((dram_cas_n[1:0] != 2'b11) && (dram_cas_n[3:2] != 2'b11)));

  p_row_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_addr));

  p_we_in_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_ras_n);

  p_oe_with_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> !dram_we_n);

  p_we_leads_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && dram_cas_n != 4'hF && $past(dram_cas_n) == 4'hF && !dram_we_n)
      |-> !$past(dram_we_n));

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  p_ack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (dram_ras_n && dram_cas_n == 4'hF));
endmodule

bind bytelane_dram_ctl bldram_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ack    (req_ack),
  .dram_addr  (dram_addr),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_dq_oe (dram_dq_oe)
);

// File: tb/test_bytelane_dram_ctl.sv
module test_bytelane_dram_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int RF_INT     = 64;

  logic        clk, rst_n;
  logic        req_valid, req_we, req_ack;
  logic [16:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata, req_rdata;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_we_n, dram_dq_oe;
  logic [3:0]  dram_cas_n;
  logic [15:0] dram_dq_out, dram_dq_in;

  bytelane_dram_ctl #(.REFRESH_INTERVAL(RF_INT)) i_bytelane_dram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ack(req_ack), .req_rdata(req_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [7:0] dram_mem [int];
  logic [7:0] ref_mem  [int];

  function automatic int key(input int bank, input int lane, input logic [7:0] row, input logic [7:0] col);
    return (bank << 17) | (lane << 16) | (int'(row) << 8) | int'(col);
  endfunction

  function automatic logic [3:0] exp_mask(input logic bank, input logic [1:0] be);
    logic [3:0] m = 4'b0;
    m[bank*2]   = be[0];
    m[bank*2+1] = be[1];
    return m;
  endfunction

  logic       prev_ras, prev_we_n, prev_oe;
  logic [3:0] prev_cas;
  logic [7:0] mon_row, mon_col;
  logic [3:0] mon_mask;
  logic       mon_we, mon_oe;
  logic [15:0] mon_dq;
  int normal_ras_cnt = 0, refresh_cnt = 0, cas_evt_cnt = 0, cycle = 0;

  always @(posedge clk) begin
    cycle++;
    if (!rst_n) begin
      prev_ras <= 1'b1; prev_cas <= 4'hF; prev_we_n <= 1'b1; prev_oe <= 1'b0;
    end else begin
      if (!dram_ras_n && prev_ras) begin
        if (dram_cas_n == 4'h0) begin
          refresh_cnt++;
          check(prev_cas == 4'h0, "R8 column strobes lead row strobe", 32'(prev_cas), 32'h0);
        end else begin
          normal_ras_cnt++;
          mon_row = dram_addr;
        end
      end
      if (prev_cas == 4'hF && dram_cas_n == 4'h0)
        check(dram_ras_n == 1'b1, "R9 refresh starts with row strobe idle", 32'(dram_ras_n), 32'h1);
      if (prev_cas == 4'hF && dram_cas_n != 4'hF && !dram_ras_n) begin
        cas_evt_cnt++;
        mon_mask = ~dram_cas_n;
        mon_col  = dram_addr;
        mon_we   = ~prev_we_n;
        mon_oe   = prev_oe;
        mon_dq   = dram_dq_out;
        if (!dram_we_n)
          for (int b = 0; b < 2; b++)
            for (int l = 0; l < 2; l++)
              if (mon_mask[b*2+l]) dram_mem[key(b, l, mon_row, mon_col)] = dram_dq_out[l*8 +: 8];
      end
      prev_ras <= dram_ras_n; prev_cas <= dram_cas_n;
      prev_we_n <= dram_we_n; prev_oe <= dram_dq_oe;
    end
  end

  always @(negedge clk) begin : model_read
    logic [15:0] v;
    v = 16'hDEAD;
    if (!dram_ras_n && dram_cas_n != 4'hF && dram_cas_n != 4'h0)
      for (int b = 0; b < 2; b++)
        for (int l = 0; l < 2; l++)
          if (!dram_cas_n[b*2+l]) begin
            int k;
            k = key(b, l, mon_row, dram_addr);
            v[l*8 +: 8] = dram_mem.exists(k) ? dram_mem[k] : 8'h00;
          end
    dram_dq_in = v;
  end

  function automatic logic [15:0] exp_read(input logic [16:0] a, input logic [1:0] be);
    logic [15:0] r = 16'h0;
    for (int l = 0; l < 2; l++)
      if (be[l]) begin
        int k;
        k = key(a[16], l, a[15:8], a[7:0]);
        r[l*8 +: 8] = ref_mem.exists(k) ? ref_mem[k] : 8'h00;
      end
    return r;
  endfunction

  task automatic do_access(input logic we, input logic [16:0] a, input logic [1:0] be, input logic [15:0] wd);
    int n = 0;
    int cas0 = cas_evt_cnt;
    int ras0 = normal_ras_cnt;
    logic [15:0] expd;
    req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    @(negedge clk);
    while (!req_ack && n < 200) begin @(negedge clk); n++; end
    check(n < 200, "R7 acknowledge arrives", 32'(n), 32'd0);
    expd = exp_read(a, be);
    if (be == 2'b00) begin
      check(cas_evt_cnt == cas0 && normal_ras_cnt == ras0, "R7 no strobe without byte enable",
            32'(cas_evt_cnt - cas0), 32'h0);
    end else begin
      check(cas_evt_cnt == cas0 + 1, "R7 one column cycle per request", 32'(cas_evt_cnt - cas0), 32'h1);
      check(mon_mask == exp_mask(a[16], be), (be == 2'b11) ? "R3 word strobes" : "R4 byte strobe",
            32'(mon_mask), 32'(exp_mask(a[16], be)));
      check((mon_mask[3:2] != 0) == a[16], "R2 bank select", 32'(mon_mask), 32'(a[16]));
      check({mon_row, mon_col} == a[15:0], "R1 row and column address", {16'h0, mon_row, mon_col}, 32'(a[15:0]));
      if (we) begin
        check(mon_we && mon_oe, "R5 write enable before column strobe", {mon_we, mon_oe}, 32'h3);
        for (int l = 0; l < 2; l++)
          if (be[l]) begin
            check(mon_dq[l*8 +: 8] == wd[l*8 +: 8], "R5 lane write data", 32'(mon_dq), 32'(wd));
            ref_mem[key(a[16], l, a[15:8], a[7:0])] = wd[l*8 +: 8];
          end
      end else begin
        check(!mon_we && !mon_oe, "R5 read leaves bus undriven", {mon_we, mon_oe}, 32'h0);
        check(req_rdata == expd, "R6 read data", 32'(req_rdata), 32'(expd));
      end
    end
    @(negedge clk);
    check(!req_ack, "R7 acknowledge single cycle", 32'(req_ack), 32'h0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R7 run did not complete actual=0 expected=1");
      finish_run();
    end
  end

  logic [16:0] pool [16];

  initial begin
    int r0, c0;
    void'($urandom(32'h5EED1));
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_cas_n == 4'hF && dram_we_n, "R10 strobes idle in reset",
          {dram_ras_n, dram_cas_n, dram_we_n}, 32'h3F);
    check(!dram_dq_oe && !req_ack && req_rdata == 16'h0, "R10 bus and ack idle in reset",
          {dram_dq_oe, req_ack, req_rdata}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    do_access(1'b1, 17'h00001, 2'b11, 16'hA55A);
    do_access(1'b0, 17'h00001, 2'b11, 16'h0);
    do_access(1'b1, 17'h1FFFF, 2'b10, 16'hC3FF);
    do_access(1'b1, 17'h1FFFF, 2'b01, 16'h0077);
    do_access(1'b0, 17'h1FFFF, 2'b11, 16'h0);
    do_access(1'b0, 17'h1FFFF, 2'b01, 16'h0);
    do_access(1'b0, 17'h00001, 2'b10, 16'h0);
    do_access(1'b1, 17'h10001, 2'b11, 16'h1234);
    do_access(1'b0, 17'h00001, 2'b11, 16'h0);
    do_access(1'b1, 17'h00001, 2'b00, 16'hFFFF);
    do_access(1'b0, 17'h00001, 2'b00, 16'h0);
    do_access(1'b0, 17'h00001, 2'b11, 16'h0);

    for (int i = 0; i < 16; i++) pool[i] = 17'($urandom);
    pool[0] = 17'h00000; pool[1] = 17'h0FFFF; pool[2] = 17'h10000; pool[3] = 17'h1FF00;
    for (int i = 0; i < 300; i++)
      do_access(1'($urandom), pool[$urandom_range(0, 15)], 2'($urandom), 16'($urandom));

    req_valid = 1'b0;
    r0 = refresh_cnt;
    repeat (RF_INT * 10) @(negedge clk);
    check(refresh_cnt - r0 >= 9 && refresh_cnt - r0 <= 11, "R8 refresh rate when idle",
          32'(refresh_cnt - r0), 32'd10);

    r0 = refresh_cnt; c0 = cycle;
    for (int i = 0; i < 150; i++)
      do_access(1'($urandom), pool[$urandom_range(0, 15)], 2'b11, 16'($urandom));
    check(refresh_cnt - r0 >= (cycle - c0) / RF_INT - 1, "R9 refresh kept under load",
          32'(refresh_cnt - r0), 32'((cycle - c0) / RF_INT));
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule